// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces a one-cycle tick whose average spacing is a whole number of input clocks plus a fraction in sixteenths of a clock. Two channel kinds share it. The infrared sample-clock channel divides the system clock straight down toward a 1.8432 MHz tick. The UART channel divides by a multiple of sixteen clocks. In both cases a 4-bit fraction is added on top.

The fraction is carried by a 4-bit phase accumulator. The fraction is added to it once per output period, and every carry out lengthens the following period by one clock. Over sixteen periods the added clocks therefore sum to exactly the fraction numerator. A configuration write restarts the period counter and clears the accumulator, so a new setting never produces a shortened tick. The enable input freezes the generator at its reload point. The block has only control and status pins; no data stream passes through it, so there is no valid/ready handshake.

In the requirements, N is the base period. N = cfg_int + 1 for the infrared channel and N = (cfg_int + 1) × 16 for the UART channel. f is the fraction numerator, so the fraction is f/16 of a clock.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is applied and after it is released, tick is low and cfg_err is high, because the reset configuration is the infrared channel with a zero integer field.
- R2: With cfg_uart = 0, a legal integer field k (1 to 15) and fraction 0, tick rises every k + 1 clocks.
- R3: With cfg_uart = 1, an integer field k (0 to 15) and fraction 0, tick rises every (k + 1) × 16 clocks.
- R4: With fraction f, the interval from tick j to tick j+1 is N + floor((j+1)·f/16) − floor(j·f/16) clocks. Tick 0 is the first tick after a restart. Any 16 consecutive intervals therefore total 16·N + f clocks, and every interval is N or N + 1.
- R5: Capturing cfg_uart = 0 with cfg_int = 0 sets cfg_err and keeps tick low for as long as that setting stands. With cfg_uart = 1, a zero integer field is legal and clears cfg_err.
- R6: cfg_wr captures cfg_uart, cfg_int and cfg_frac on a rising edge. Tick is low in the cycle after that edge. The first tick appears after N − 1 further edges, and the interval that follows it is not stretched.
- R7: While en is low, tick stays low and the counter and accumulator are held at their restart values. When en returns high, the first tick appears after the (N − 1)th rising edge sampled with en high, and the next interval is N.
- R8: Tick is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock the tick is divided from |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the generator at its reload point |
| cfg_wr | input | 1 | Capture strobe for the three configuration inputs |
| cfg_uart | input | 1 | Channel kind: 0 infrared (divide by field+1), 1 UART (divide by (field+1)×16) |
| cfg_int | input | 4 | Integer divisor field, stored as divisor minus one |
| cfg_frac | input | 4 | Fraction numerator in sixteenths of a clock |
| tick | output | 1 | One-cycle output pulse |
| cfg_err | output | 1 | High while the captured setting is illegal |

## Verification
On every cycle the assertions check several properties. The tick is one cycle wide, and it is silent in the cycle after any hold and under an illegal setting. The counter never exceeds its stretched reload value. The accumulator moves downward exactly when it carries and never otherwise. Only the bench scenarios can show the timing over a whole period and over many periods: the exact interval sequence for each fraction, the 16-interval total, the first-tick latency after a write or after re-enable, and the contrast between the two channel kinds.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  // Channel kind selected by the configuration write.
  typedef enum logic {
    CH_IR   = 1'b0,
    CH_UART = 1'b1
  } chan_e;

endpackage

// File: rtl/fbg_cfg.sv
module fbg_cfg
  import fbg_pkg::*;
#(
  parameter int INT_W = 4,
  parameter int FRAC_W = 4,
  parameter int OSR = 16,
  parameter int LEN_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              uart_in,
  input  logic [INT_W-1:0]  int_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [FRAC_W-1:0] frac_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [LEN_W-1:0]  len_d,
  output logic              err_q
);

  localparam bit OSR_POW2 = ((OSR & (OSR - 1)) == 0);
  localparam int OSR_SH = (OSR > 1) ? $clog2(OSR) : 0;

  chan_e chan_in;
  chan_e chan_q;
  logic [LEN_W-1:0] base_in;
  logic [LEN_W-1:0] scaled_in;
  logic [LEN_W-1:0] new_len;
  logic             new_err;

  assign chan_in = uart_in ? CH_UART : CH_IR;
  assign base_in = LEN_W'(int_in) + LEN_W'(1);

  // The oversampling scale is a shift when it is a power of two.
  generate
    if (OSR_POW2) begin : g_shift
      assign scaled_in = base_in << OSR_SH;
    end else begin : g_mul
      assign scaled_in = base_in * LEN_W'(OSR);
    end
  endgenerate

  assign new_len = (chan_in == CH_UART) ? scaled_in : base_in;
  assign new_err = (chan_in == CH_IR) && (int_in == '0);
  assign len_d   = wr ? new_len : len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q <= CH_IR;
      frac_q <= '0;
      len_q  <= LEN_W'(1);
      err_q  <= 1'b1;
    end else if (wr) begin
      chan_q <= chan_in;
      frac_q <= frac_in;
      len_q  <= new_len;
      err_q  <= new_err;
    end
  end

  // R5
  legal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_q |-> (len_q >= LEN_W'(2)));

  // R3
  uart_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_q == CH_UART) |-> (len_q >= LEN_W'(OSR)));

endmodule

// File: rtl/fbg_phase_acc.sv
module fbg_phase_acc #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, frac};
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc_q <= '0;
    end else if (advance) begin
      acc_q <= sum[FRAC_W-1:0];
    end
  end

  // R4
  acc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear && carry) |=> (acc_q < $past(acc_q)));

  // R4
  acc_nocarry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear && !carry) |=> (acc_q >= $past(acc_q)));

endmodule

// File: rtl/fbg_period_cnt.sv
module fbg_period_cnt #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             live,
  input  logic [LEN_W-1:0] len_d,
  input  logic [LEN_W-1:0] len_q,
  input  logic             stretch,
  output logic             tick
);

  logic [LEN_W-1:0] cnt_q;

  assign tick = live && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hold) begin
      cnt_q <= len_d - LEN_W'(1);
    end else if (cnt_q == '0) begin
      cnt_q <= len_q - LEN_W'(1) + LEN_W'(stretch);
    end else begin
      cnt_q <= cnt_q - LEN_W'(1);
    end
  end

  // R8
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R6 R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !tick);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= len_q);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int INT_W = 4,
  parameter int FRAC_W = 4,
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cfg_wr,
  input  logic              cfg_uart,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_frac,
  output logic              tick,
  output logic              cfg_err
);

  localparam int MAX_LEN = (2 ** INT_W) * OSR;
  localparam int LEN_W = $clog2(MAX_LEN + 2);

  logic [FRAC_W-1:0] frac_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  len_d;
  logic              err_q;
  logic              hold;
  logic              live;
  logic              stretch;

  fbg_cfg #(
    .INT_W (INT_W),
    .FRAC_W(FRAC_W),
    .OSR   (OSR),
    .LEN_W (LEN_W)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .uart_in(cfg_uart),
    .int_in (cfg_int),
    .frac_in(cfg_frac),
    .frac_q (frac_q),
    .len_q  (len_q),
    .len_d  (len_d),
    .err_q  (err_q)
  );

  assign live = en && !err_q;
  assign hold = cfg_wr || !live;

  fbg_phase_acc #(
    .FRAC_W(FRAC_W)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (hold),
    .advance(tick),
    .frac   (frac_q),
    .carry  (stretch)
  );

  fbg_period_cnt #(
    .LEN_W(LEN_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .live   (live),
    .len_d  (len_d),
    .len_q  (len_q),
    .stretch(stretch),
    .tick   (tick)
  );

  assign cfg_err = err_q;

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !tick);

  // R7
  en_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick);

endmodule

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       cfg_wr = 1'b0;
  logic       cfg_uart = 1'b0;
  logic [3:0] cfg_int = '0;
  logic [3:0] cfg_frac = '0;
  logic       tick;
  logic       cfg_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frac_baud_gen u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .cfg_wr  (cfg_wr),
    .cfg_uart(cfg_uart),
    .cfg_int (cfg_int),
    .cfg_frac(cfg_frac),
    .tick    (tick),
    .cfg_err (cfg_err)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int base_len(bit u, int i);
    return u ? (i + 1) * 16 : (i + 1);
  endfunction

  function automatic int exp_gap(int n, int f, int j);
    return n + ((j + 1) * f) / 16 - (j * f) / 16;
  endfunction

  task automatic cfg_write(bit u, int i, int f);
    @(negedge clk);
    cfg_uart = u;
    cfg_int  = 4'(i);
    cfg_frac = 4'(f);
    cfg_wr   = 1'b1;
    @(negedge clk);
    cfg_wr   = 1'b0;
  endtask

  // Write a setting, then record 17 ticks and compare their spacing.
  task automatic run_check(bit u, int i, int f);
    int n;
    int c;
    int k;
    int t[17];
    bit prev;
    bit dbl;
    string rq;
    n = base_len(u, i);
    rq = (f != 0) ? "R4" : (u ? "R3" : "R2");
    cfg_write(u, i, f);
    chk(tick == 1'b0, "R6 tick after write", int'(tick), 0);
    chk(cfg_err == 1'b0, "R5 legal setting", int'(cfg_err), 0);
    c = 1;
    k = 0;
    prev = 1'b0;
    dbl = 1'b0;
    while (k < 17 && c < 17 * (n + 1) + 10) begin
      if (tick) begin
        if (prev) dbl = 1'b1;
        t[k] = c;
        k++;
      end
      prev = tick;
      @(negedge clk);
      c++;
    end
    chk(k == 17, "R4 tick count", k, 17);
    chk(!dbl, "R8 single-cycle tick", int'(dbl), 0);
    if (k == 17) begin
      chk(t[0] == n, "R6 first tick latency", t[0], n);
      chk(t[1] - t[0] == n, "R6 first interval unstretched", t[1] - t[0], n);
      for (int j = 0; j < 16; j++) begin
        chk(t[j + 1] - t[j] == exp_gap(n, f, j), rq, t[j + 1] - t[j], exp_gap(n, f, j));
      end
      chk(t[16] - t[0] == 16 * n + f, "R4 sixteen-interval total", t[16] - t[0], 16 * n + f);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int c;
    bit seen;
    bit allerr;
    void'($urandom(32'h5eed_1234));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
    chk(cfg_err == 1'b1, "R1 err in reset", int'(cfg_err), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(tick == 1'b0, "R1 tick after reset", int'(tick), 0);
    chk(cfg_err == 1'b1, "R1 err after reset", int'(cfg_err), 1);

    // Directed corners
    run_check(1'b0, 1, 0);
    run_check(1'b0, 1, 15);
    run_check(1'b0, 15, 15);
    run_check(1'b1, 0, 0);
    run_check(1'b1, 0, 15);
    run_check(1'b1, 15, 1);
    run_check(1'b0, 5, 8);

    // R5: illegal infrared setting
    cfg_write(1'b0, 0, 7);
    seen = 1'b0;
    allerr = 1'b1;
    for (int j = 0; j < 60; j++) begin
      if (tick) seen = 1'b1;
      if (!cfg_err) allerr = 1'b0;
      @(negedge clk);
    end
    chk(!seen, "R5 no tick while illegal", int'(seen), 0);
    chk(allerr, "R5 err held", int'(allerr), 1);

    // R7: enable hold, then resume
    cfg_write(1'b0, 3, 5);
    n = base_len(1'b0, 3);
    en = 1'b0;
    seen = 1'b0;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (tick) seen = 1'b1;
    end
    chk(!seen, "R7 no tick while disabled", int'(seen), 0);
    en = 1'b1;
    c = 0;
    seen = 1'b0;
    while (!seen && c < 50) begin
      @(negedge clk);
      c++;
      if (tick) seen = 1'b1;
    end
    chk(c == n - 1, "R7 first tick after enable", c, n - 1);
    c = 0;
    seen = 1'b0;
    while (!seen && c < 50) begin
      @(negedge clk);
      c++;
      if (tick) seen = 1'b1;
    end
    chk(c == n, "R7 interval after enable", c, n);

    // Constrained random settings
    for (int r = 0; r < 12; r++) begin
      bit u;
      int i;
      int f;
      u = 1'($urandom % 2);
      i = u ? int'($urandom % 8) : int'(1 + $urandom % 15);
      f = int'($urandom % 16);
      run_check(u, i, f);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule